// File: doc/BRIEF.md
# ECC Error Event Counter Bank

This block sits behind the ECC checker of a memory controller. It tallies the checker's corrected-error (CE) and uncorrected-error (UE) reports so that slowly failing memory modules can be found before they cause data loss. Each report carries a channel index and a slot index. The controller has 3 channels of 3 slots each. A presence mask maps every populated slot to a module row. Rows are numbered in channel-major order, and empty slots are skipped.

Two views of the same events are kept. In the first, every module row has its own CE and UE counters. In the second, every slot index has one CE and one UE counter, shared by that slot position across all channels. Beside these sit controller-wide CE and UE totals, CE and UE counters for reports that carry no usable location, and a seconds-since-clear counter.

A small register port gives read access to all counters. It also holds three control bits: CE logging, UE logging and halt-on-UE. Writing to the clear register zeroes every counter. The block drives a one-cycle log request that tells whether the logged event is a UE. It also drives a sticky panic request.

Top module: `ecc_evt_bank`

## Requirements
- R1: After reset every counter reads 0, the control register reads 0, and logStb, logIsUe and panicReq are low.
- R2: A CE with a valid location increments three counters: the CE counter of its row, the aggregate CE counter of its slot index, and the CE total. The row of slot s on channel c is the number of present slots whose flat index (c*3+s, and bit c*3+s of slotPresent) is lower than its own. Row r CE is read at address 0x10+r, aggregate slot k CE at 0x30+k, and the CE total at 0x02.
- R3: A UE with a valid location, while halt-on-UE is off, increments three counters: the UE counter of its row (address 0x20+r), the aggregate UE counter of its slot (0x38+k), and the UE total (0x03).
- R4: Some events have no usable location: evtNoInfo is set, the slot is absent in slotPresent, the channel is 3 or above, or the slot is 3 or above. Such an event increments only the no-location CE counter (0x04) or the no-location UE counter (0x05).
- R5: Until a counter saturates, the CE and UE totals equal the sums of the per-row CE and UE counters. No-location events are not included in the totals.
- R6: Every counter saturates at all-ones and holds that value. It never wraps.
- R7: Any write to address 0x01 zeroes every counter and the seconds counter, and drops panicReq. If an event arrives in the same cycle, the clear wins. The control register keeps its value.
- R8: The seconds counter (0x06) increments once every SEC_DIV cycles, counted from reset or from the last clear. It saturates like any other counter.
- R9: One cycle after an event, logStb is high if the enable for that event's type is set. Control bit 0 enables CE logging and bit 1 enables UE logging. logIsUe is high when the logged event is a UE.
- R10: The log enables have no effect on counting.
- R11: With control bit 2 (halt-on-UE) set, a UE raises panicReq on the next cycle, and panicReq stays high until a clear or a reset. Such a UE increments no UE counter. A CE in the same cycle is still counted.
- R12: A CE and a UE in the same cycle are both counted. Only the UE is offered to the log: logStb follows the UE enable, and logIsUe is high when that enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceValid | input | 1 | Corrected-error report this cycle |
| ueValid | input | 1 | Uncorrected-error report this cycle |
| evtNoInfo | input | 1 | The report carries no location |
| evtCh | input | 2 | Channel index of the report |
| evtSlot | input | 2 | Slot index of the report |
| slotPresent | input | 9 | Populated-slot mask, bit c*3+s |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWdata | input | CNT_W | Write data (control register bits 2:0) |
| regRdata | output | CNT_W | Read data for regAddr, combinational |
| logStb | output | 1 | One-cycle log request |
| logIsUe | output | 1 | The logged event is a UE |
| panicReq | output | 1 | Sticky panic request |

## Verification
A row-mapping error increments the wrong row counter in the same cycle as the event. The next read of that row shows the error, and the aggregate counter for the slot still looks correct. A wrong prescaler phase shows up in the seconds counter at most SEC_DIV cycles later. A saturation fault appears as a wrap to zero on the first event after all-ones. Log and panic faults appear exactly one cycle after the event, so the bench compares those pins on every clock and sweeps the full register space after each group of events.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 6'h01;
  localparam logic [ADDR_W-1:0] ADR_CTOT = 6'h02;
  localparam logic [ADDR_W-1:0] ADR_UTOT = 6'h03;
  localparam logic [ADDR_W-1:0] ADR_CNI  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_UNI  = 6'h05;
  localparam logic [ADDR_W-1:0] ADR_SEC  = 6'h06;
  localparam logic [ADDR_W-1:0] ADR_DCE  = 6'h10;  // up to 16 rows
  localparam logic [ADDR_W-1:0] ADR_DUE  = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_ACE  = 6'h30;  // up to 8 slots
  localparam logic [ADDR_W-1:0] ADR_AUE  = 6'h38;

  // strobes from control to datapath, one cycle's worth of work
  typedef struct packed {
    logic clrAll;
    logic secTick;
    logic ceInc;
    logic ueInc;
    logic locOk;
  } cntStrb_t;
endpackage

// File: rtl/ecc_evt_ctrl.sv
module ecc_evt_ctrl
  import ecc_evt_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int SEC_DIV  = 50000000,
  localparam int NUM_DIMM = NUM_CH * NUM_SLOT,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SLOT_W   = $clog2(NUM_SLOT),
  localparam int ROW_W    = $clog2(NUM_DIMM),
  localparam int DIV_W    = $clog2(SEC_DIV)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceValid,
  input  logic                ueValid,
  input  logic                evtNoInfo,
  input  logic [CH_W-1:0]     evtCh,
  input  logic [SLOT_W-1:0]   evtSlot,
  input  logic [NUM_DIMM-1:0] slotPresent,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [2:0]          wrBits,
  output cntStrb_t            strb,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [2:0]          ctrlBits,
  output logic                logStb,
  output logic                logIsUe,
  output logic                panicReq
);
  logic logCeEn, logUeEn, panicOn;
  logic [DIV_W-1:0] divCnt;
  logic clrHit, inRange, locOk;
  int flatIdx, rowCnt;

  assign clrHit  = regWe && (regAddr == ADR_CLR);
  assign inRange = (int'(evtCh) < NUM_CH) && (int'(evtSlot) < NUM_SLOT);

  // row = number of populated slots ahead of this one, channel-major
  always_comb begin
    flatIdx = int'(evtCh) * NUM_SLOT + int'(evtSlot);
    rowCnt  = 0;
    locOk   = 1'b0;
    for (int i = 0; i < NUM_DIMM; i++) begin
      if (i == flatIdx) locOk = slotPresent[i];
      else if (i < flatIdx && slotPresent[i]) rowCnt = rowCnt + 1;
    end
    locOk = locOk && inRange && !evtNoInfo;
  end
  assign rowIdx = ROW_W'(rowCnt);

  assign strb.clrAll  = clrHit;
  assign strb.secTick = (divCnt == DIV_W'(SEC_DIV - 1));
  assign strb.ceInc   = ceValid;
  assign strb.ueInc   = ueValid && !panicOn;
  assign strb.locOk   = locOk;
  assign ctrlBits     = {panicOn, logUeEn, logCeEn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {panicOn, logUeEn, logCeEn} <= 3'b000;
    end else if (regWe && regAddr == ADR_CTRL) begin
      {panicOn, logUeEn, logCeEn} <= wrBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrHit)   divCnt <= '0;
    else if (strb.secTick) divCnt <= '0;
    else                   divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logStb   <= 1'b0;
      logIsUe  <= 1'b0;
      panicReq <= 1'b0;
    end else begin
      logStb  <= ueValid ? logUeEn : (ceValid && logCeEn);
      logIsUe <= ueValid && logUeEn;
      if (clrHit)                  panicReq <= 1'b0;
      else if (ueValid && panicOn) panicReq <= 1'b1;
    end
  end

  AST_PANIC_SET: assert property (@(posedge clk) disable iff (!rstN)
    (ueValid && panicOn && !clrHit) |=> panicReq);  // R11
  AST_LOG_SRC: assert property (@(posedge clk) disable iff (!rstN)
    logStb |-> $past(ceValid || ueValid));  // R9
  AST_UE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ueValid && ceValid && logUeEn) |=> (logStb && logIsUe));  // R12
endmodule

// File: rtl/ecc_evt_cnt.sv
module ecc_evt_cnt
  import ecc_evt_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int CNT_W    = 32,
  localparam int NUM_DIMM = NUM_CH * NUM_SLOT,
  localparam int SLOT_W   = $clog2(NUM_SLOT),
  localparam int ROW_W    = $clog2(NUM_DIMM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrb_t          strb,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [SLOT_W-1:0] slotIdx,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0]        ctrlBits,
  output logic [CNT_W-1:0]  regRdata
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] ceTot, ueTot, ceNoInfo, ueNoInfo, secCnt;
  logic [CNT_W-1:0] dimmCe [NUM_DIMM];
  logic [CNT_W-1:0] dimmUe [NUM_DIMM];
  logic [CNT_W-1:0] aggCe [NUM_SLOT];
  logic [CNT_W-1:0] aggUe [NUM_SLOT];
  logic ceLoc, ueLoc;

  assign ceLoc = strb.ceInc && strb.locOk;
  assign ueLoc = strb.ueInc && strb.locOk;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      ceTot <= '0; ueTot <= '0; ceNoInfo <= '0; ueNoInfo <= '0; secCnt <= '0;
    end else begin
      if (ceLoc) ceTot <= bump(ceTot);
      if (ueLoc) ueTot <= bump(ueTot);
      if (strb.ceInc && !strb.locOk) ceNoInfo <= bump(ceNoInfo);
      if (strb.ueInc && !strb.locOk) ueNoInfo <= bump(ueNoInfo);
      if (strb.secTick) secCnt <= bump(secCnt);
    end
  end

  for (genvar g = 0; g < NUM_DIMM; g++) begin : gRow
    logic [CNT_W-1:0] ceQ, ueQ;
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrAll) begin
        ceQ <= '0; ueQ <= '0;
      end else begin
        if (ceLoc && rowIdx == ROW_W'(g)) ceQ <= bump(ceQ);
        if (ueLoc && rowIdx == ROW_W'(g)) ueQ <= bump(ueQ);
      end
    end
    assign dimmCe[g] = ceQ;
    assign dimmUe[g] = ueQ;
  end

  for (genvar k = 0; k < NUM_SLOT; k++) begin : gSlot
    logic [CNT_W-1:0] ceQ, ueQ;
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrAll) begin
        ceQ <= '0; ueQ <= '0;
      end else begin
        if (ceLoc && slotIdx == SLOT_W'(k)) ceQ <= bump(ceQ);
        if (ueLoc && slotIdx == SLOT_W'(k)) ueQ <= bump(ueQ);
      end
    end
    assign aggCe[k] = ceQ;
    assign aggUe[k] = ueQ;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_CTRL: regRdata = CNT_W'(ctrlBits);
      ADR_CTOT: regRdata = ceTot;
      ADR_UTOT: regRdata = ueTot;
      ADR_CNI:  regRdata = ceNoInfo;
      ADR_UNI:  regRdata = ueNoInfo;
      ADR_SEC:  regRdata = secCnt;
      default: ;
    endcase
    for (int r = 0; r < NUM_DIMM; r++) begin
      if (regAddr == ADR_DCE + ADDR_W'(r)) regRdata = dimmCe[r];
      if (regAddr == ADR_DUE + ADDR_W'(r)) regRdata = dimmUe[r];
    end
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (regAddr == ADR_ACE + ADDR_W'(k)) regRdata = aggCe[k];
      if (regAddr == ADR_AUE + ADDR_W'(k)) regRdata = aggUe[k];
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (ceTot == '0 && ueTot == '0 && ceNoInfo == '0 &&
                     ueNoInfo == '0 && secCnt == '0));  // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ((&ceTot) && !strb.clrAll) |=> (&ceTot));  // R6
  AST_TOT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrAll |=> (ceTot == $past(ceTot) || ceTot == $past(ceTot) + 1'b1));  // R5
  AST_NOINFO_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ceInc && !strb.locOk && !strb.clrAll) |=> $stable(ceTot));  // R4
endmodule

// File: rtl/ecc_evt_bank.sv
module ecc_evt_bank
  import ecc_evt_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_SLOT = 3,
  parameter int CNT_W    = 32,
  parameter int SEC_DIV  = 50000000,
  localparam int NUM_DIMM = NUM_CH * NUM_SLOT,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int SLOT_W   = $clog2(NUM_SLOT),
  localparam int ROW_W    = $clog2(NUM_DIMM)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceValid,
  input  logic                ueValid,
  input  logic                evtNoInfo,
  input  logic [CH_W-1:0]     evtCh,
  input  logic [SLOT_W-1:0]   evtSlot,
  input  logic [NUM_DIMM-1:0] slotPresent,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CNT_W-1:0]    regWdata,
  output logic [CNT_W-1:0]    regRdata,
  output logic                logStb,
  output logic                logIsUe,
  output logic                panicReq
);
  cntStrb_t         strb;
  logic [ROW_W-1:0] rowIdx;
  logic [2:0]       ctrlBits;

  ecc_evt_ctrl #(.NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .SEC_DIV(SEC_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceValid(ceValid), .ueValid(ueValid),
    .evtNoInfo(evtNoInfo), .evtCh(evtCh), .evtSlot(evtSlot),
    .slotPresent(slotPresent), .regWe(regWe), .regAddr(regAddr),
    .wrBits(regWdata[2:0]), .strb(strb), .rowIdx(rowIdx), .ctrlBits(ctrlBits),
    .logStb(logStb), .logIsUe(logIsUe), .panicReq(panicReq)
  );

  ecc_evt_cnt #(.NUM_CH(NUM_CH), .NUM_SLOT(NUM_SLOT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .strb(strb), .rowIdx(rowIdx), .slotIdx(evtSlot),
    .regAddr(regAddr), .ctrlBits(ctrlBits), .regRdata(regRdata)
  );
endmodule

// File: tb/ecc_evt_bank_tb.sv
`timescale 1ns/1ps
module ecc_evt_bank_tb;
  localparam int NCH = 3, NSL = 3, CW = 4, DIV = 8, ND = 9;
  localparam int MAXV = (1 << CW) - 1;
  localparam logic [ND-1:0] PRES = 9'b110101011;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rstN, ceValid, ueValid, evtNoInfo, regWe;
  logic [1:0] evtCh, evtSlot;
  logic [5:0] regAddr;
  logic [CW-1:0] regWdata, regRdata;
  logic logStb, logIsUe, panicReq;

  ecc_evt_bank #(.NUM_CH(NCH), .NUM_SLOT(NSL), .CNT_W(CW), .SEC_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .ceValid(ceValid), .ueValid(ueValid),
    .evtNoInfo(evtNoInfo), .evtCh(evtCh), .evtSlot(evtSlot), .slotPresent(PRES),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .logStb(logStb), .logIsUe(logIsUe), .panicReq(panicReq)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;
  int mDce[ND], mDue[ND], mAce[NSL], mAue[NSL];
  int mCt, mUt, mCn, mUn, mSec, mPresc;
  bit mLogCe, mLogUe, mPanOn, mPanic, eStb, eIsUe;

  function automatic int sat(int v);
    return (v < MAXV) ? v + 1 : MAXV;
  endfunction

  task automatic chk(int act, int exp, string tag);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelZero();
    for (int i = 0; i < ND; i++) begin mDce[i] = 0; mDue[i] = 0; end
    for (int k = 0; k < NSL; k++) begin mAce[k] = 0; mAue[k] = 0; end
    mCt = 0; mUt = 0; mCn = 0; mUn = 0; mSec = 0; mPresc = 0; mPanic = 0;
  endtask

  task automatic modelStep();
    int ch, sl, flat, row;
    bit loc;
    ch = int'(evtCh); sl = int'(evtSlot);
    flat = ch * NSL + sl;
    row = 0;
    loc = !evtNoInfo && ch < NCH && sl < NSL && PRES[flat];
    for (int i = 0; i < ND; i++) if (i < flat && PRES[i]) row++;
    if (ueValid) begin eStb = mLogUe; eIsUe = mLogUe; end
    else begin eStb = ceValid && mLogCe; eIsUe = 0; end
    if (regWe && regAddr == 6'h01) begin
      modelZero();
    end else begin
      if (mPresc == DIV - 1) begin mPresc = 0; mSec = sat(mSec); end
      else mPresc++;
      if (ueValid && mPanOn) mPanic = 1;
      if (ceValid) begin
        if (loc) begin mDce[row] = sat(mDce[row]); mAce[sl] = sat(mAce[sl]); mCt = sat(mCt); end
        else mCn = sat(mCn);
      end
      if (ueValid && !mPanOn) begin
        if (loc) begin mDue[row] = sat(mDue[row]); mAue[sl] = sat(mAue[sl]); mUt = sat(mUt); end
        else mUn = sat(mUn);
      end
    end
    if (regWe && regAddr == 6'h00) {mPanOn, mLogUe, mLogCe} = regWdata[2:0];
  endtask

  function automatic int expRd(int a);
    if (a == 0) return {mPanOn, mLogUe, mLogCe};
    if (a == 2) return mCt;
    if (a == 3) return mUt;
    if (a == 4) return mCn;
    if (a == 5) return mUn;
    if (a == 6) return mSec;
    if (a >= 16 && a < 16 + ND) return mDce[a - 16];
    if (a >= 32 && a < 32 + ND) return mDue[a - 32];
    if (a >= 48 && a < 48 + NSL) return mAce[a - 48];
    if (a >= 56 && a < 56 + NSL) return mAue[a - 56];
    return 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    modelStep();
    #2;
    chk(int'(logStb), int'(eStb), "R9 logStb");
    chk(int'(logIsUe), int'(eIsUe), "R9 logIsUe");
    chk(int'(panicReq), int'(mPanic), "R11 panicReq");
    @(negedge clk);
    ceValid = 0; ueValid = 0; evtNoInfo = 0; regWe = 0;
  endtask

  task automatic ev(bit ce, bit ue, bit ni, int ch, int sl);
    ceValid = ce; ueValid = ue; evtNoInfo = ni;
    evtCh = 2'(ch); evtSlot = 2'(sl);
    tick();
  endtask

  task automatic wr(int a, int d);
    regWe = 1; regAddr = 6'(a); regWdata = CW'(d);
    tick();
  endtask

  task automatic rdAll(string tag);
    for (int a = 0; a < 64; a++) begin
      regAddr = 6'(a);
      #1;
      chk(int'(regRdata), expRd(a), $sformatf("%s addr=%0d", tag, a));
      tick();
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 0; ceValid = 0; ueValid = 0; evtNoInfo = 0; regWe = 0;
    evtCh = 0; evtSlot = 0; regAddr = 0; regWdata = 0;
    mLogCe = 0; mLogUe = 0; mPanOn = 0; eStb = 0; eIsUe = 0;
    modelZero();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    chk(int'(logStb), 0, "R1 logStb");
    chk(int'(panicReq), 0, "R1 panicReq");
    rdAll("R1 reset");

    // located and absent slots, logging off
    for (int c = 0; c < NCH; c++) for (int s = 0; s < NSL; s++) ev(1, 0, 0, c, s);
    rdAll("R2 R10");
    for (int n = 0; n < 2; n++)
      for (int c = 0; c < NCH; c++) for (int s = 0; s < NSL; s++) ev(0, 1, 0, c, s);
    rdAll("R3");

    ev(1, 0, 1, 0, 0); ev(0, 1, 1, 1, 1); ev(1, 0, 0, 3, 0); ev(0, 1, 0, 0, 3);
    rdAll("R4");

    wr(0, 3);
    ev(1, 0, 0, 0, 1); ev(0, 1, 0, 2, 2); ev(1, 1, 0, 1, 0);
    wr(0, 1);
    ev(1, 1, 0, 1, 2); ev(1, 0, 0, 1, 2);
    rdAll("R9 R12 R5");

    for (int n = 0; n < 20; n++) ev(1, 0, 0, 0, 0);
    rdAll("R6");

    wr(1, 0);
    rdAll("R7 clear");
    ev(1, 0, 0, 2, 1);
    regWe = 1; regAddr = 6'h01; ceValid = 1; ueValid = 1; evtCh = 0; evtSlot = 0;
    tick();
    rdAll("R7 priority");

    wr(1, 0);
    for (int n = 0; n < 20; n++) begin
      regAddr = 6'h06; #1;
      chk(int'(regRdata), mSec, "R8 seconds");
      tick();
    end

    wr(0, 7);
    ev(1, 1, 0, 0, 1); ev(0, 1, 1, 0, 0);
    rdAll("R11");
    wr(1, 0);
    rdAll("R11 after clear");

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule